// File: doc/BRIEF.md
# SPI Slave Paged Register File

This block is the device side of a four-wire serial link. Through it a host reads and writes a bank of 16-bit control registers. The registers are grouped into pages of 64 addresses each. The link runs with the clock idling low. The slave puts each bit on its data output after a rising clock edge and takes each bit from its data input on the falling edge. Every transfer is full duplex and 16 bits long, most significant bit first.

After chip select goes low, the first word is a command. The command gives the direction, the page and the starting register. Every later word in the same selection is data. On a write, data words land in consecutive registers. On a read, data words return consecutive registers. Internal logic sees the stored values through a combinational parallel read port. All serial pins are brought into the system clock domain through synchronisers. The system clock must therefore run several times faster than the serial clock.

Only a parameterised number of pages and registers per page hold storage. Every other location reads as zero and ignores writes.

Top module: `spi_paged_regfile`

## Requirements
- R1: The slave drives `spi_miso` with the next bit after each rising `spi_sclk` edge and captures `spi_mosi` on each falling edge. Words are 16 bits, sent most significant bit first.
- R2: A command word has read/write in bit 15 (1 = read, 0 = write), the page in bits 14:11 and the start address in bits 10:5. Bits 4:0 have no effect on the access.
- R3: Only the first full word after a falling edge of `spi_cs_n` is decoded as a command. `spi_miso` is 0 throughout the command word and whenever chip select is high.
- R4: In a write selection, data word k is stored at the start address plus k. The address wraps from 63 to 0 inside the same page.
- R5: In a read selection, data word k returns the register at the start address plus k, with the same wrap. The words shifted in on `spi_mosi` during a read change no register.
- R6: If chip select rises before a word is complete, that partial word is dropped and nothing is written. The next selection starts again with a command.
- R7: A page at or above `NUM_PAGES`, or an address at or above `REGS_PER_PAGE`, reads as 0 and ignores writes.
- R8: Reset sets every register to 0 and returns all framing state to idle.
- R9: `par_rdata` combinationally shows the register selected by `par_page` and `par_addr`, or 0 for a location without storage.
- R10: While chip select stays low, every word after the command is data, even if it looks like a valid command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| par_page | input | 4 | Page index for the parallel read port |
| par_addr | input | 6 | Register address for the parallel read port |
| par_rdata | output | 16 | Register value for the parallel read port |

## Verification
Selections use distinct data patterns, including single-bit-at-the-ends values that expose bit order. Streaming reads that follow streaming writes tell a correct address increment and wrap apart from a stuck or off-by-one pointer. Commands with the reserved bits set, and data words shaped like read commands, separate correct command framing from decoding every word. Chip select raised mid-word, reads that shift in all-ones, and accesses to locations without storage each show whether a stray write got through. The parallel port is then scanned across implemented and unimplemented locations and compared with the bench model.

// File: rtl/spi_regfile_pkg.sv
package spi_regfile_pkg;
   localparam int WORD_W = 16;
   localparam int PAGE_W = 4;
   localparam int ADDR_W = 6;
   localparam int RSV_W  = 5;
   localparam int CMD_W  = 1 + PAGE_W + ADDR_W;

   typedef enum logic {PH_CMD = 1'b0, PH_DATA = 1'b1} phase_e;

   // Upper part of a command word; the reserved tail is not carried.
   typedef struct packed {
      logic              rd;
      logic [PAGE_W-1:0] page;
      logic [ADDR_W-1:0] addr;
   } cmd_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic cs_n_i,
   input  logic mosi_i,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_active,
   output logic mosi_s
);
   localparam int TOP = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [TOP:0] sclk_q, cs_q, mosi_q;
   logic         sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= '0;
         cs_q   <= '1;
         mosi_q <= '0;
         sclk_d <= 1'b0;
      end else begin
         sclk_q <= {sclk_q[TOP-1:0], sclk_i};
         cs_q   <= {cs_q[TOP-1:0], cs_n_i};
         mosi_q <= {mosi_q[TOP-1:0], mosi_i};
         sclk_d <= sclk_q[TOP];
      end
   end

   assign sclk_rise = sclk_q[TOP] & ~sclk_d;
   assign sclk_fall = ~sclk_q[TOP] & sclk_d;
   assign cs_active = ~cs_q[TOP];
   assign mosi_s    = mosi_q[TOP];
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
   import spi_regfile_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              mosi_s,
   input  logic [WORD_W-1:0] tx_word,
   output logic              miso,
   output logic              word_done,
   output logic [WORD_W-1:0] rx_word
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         tx_sh     <= '0;
         rx_word   <= '0;
         miso      <= 1'b0;
         word_done <= 1'b0;
      end else if (!cs_active) begin
         bit_cnt   <= '0;
         miso      <= 1'b0;
         word_done <= 1'b0;
      end else begin
         word_done <= 1'b0;
         if (sclk_rise) begin
            if (bit_cnt == '0) begin
               miso  <= tx_word[WORD_W-1];
               tx_sh <= {tx_word[WORD_W-2:0], 1'b0};
            end else begin
               miso  <= tx_sh[WORD_W-1];
               tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            end
         end
         if (sclk_fall) begin
            rx_word <= {rx_word[WORD_W-2:0], mosi_s};
            if (bit_cnt == LAST) begin
               bit_cnt   <= '0;
               word_done <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
   import spi_regfile_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              word_done,
   input  cmd_t              cmd_in,
   output phase_e            phase,
   output logic              rd_mode,
   output logic [PAGE_W-1:0] cur_page,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              wr_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_CMD;
         rd_mode  <= 1'b0;
         cur_page <= '0;
         cur_addr <= '0;
      end else if (!cs_active) begin
         phase   <= PH_CMD;
         rd_mode <= 1'b0;
      end else if (word_done) begin
         if (phase == PH_CMD) begin
            phase    <= PH_DATA;
            rd_mode  <= cmd_in.rd;
            cur_page <= cmd_in.page;
            cur_addr <= cmd_in.addr;
         end else begin
            cur_addr <= cur_addr + 1'b1;
         end
      end
   end

   assign wr_en = cs_active && word_done && (phase == PH_DATA) && !rd_mode;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
   import spi_regfile_pkg::*;
#(
   parameter int NUM_PAGES     = 2,
   parameter int REGS_PER_PAGE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PAGE_W-1:0] wr_page,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [PAGE_W-1:0] rd_page,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   input  logic [PAGE_W-1:0] par_page,
   input  logic [ADDR_W-1:0] par_addr,
   output logic [WORD_W-1:0] par_rdata
);
   localparam int TOTAL = NUM_PAGES * REGS_PER_PAGE;
   localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;

   generate
      if (NUM_PAGES < 1 || NUM_PAGES > (1 << PAGE_W)) begin : g_bad_pages
         $error("spi_reg_bank: NUM_PAGES out of range");
      end
      if (REGS_PER_PAGE < 1 || REGS_PER_PAGE > (1 << ADDR_W)) begin : g_bad_regs
         $error("spi_reg_bank: REGS_PER_PAGE out of range");
      end
   endgenerate

   logic [WORD_W-1:0] regs [TOTAL];
   logic              w_hit;
   logic [IDX_W-1:0]  w_idx;

   function automatic logic [WORD_W-1:0] fetch(input logic [PAGE_W-1:0] pg,
                                               input logic [ADDR_W-1:0] ad);
      logic [WORD_W-1:0] v;
      v = '0;
      for (int p = 0; p < NUM_PAGES; p++)
         for (int r = 0; r < REGS_PER_PAGE; r++)
            if (pg == PAGE_W'(p) && ad == ADDR_W'(r))
               v = regs[p*REGS_PER_PAGE + r];
      return v;
   endfunction

   always_comb begin
      w_hit = 1'b0;
      w_idx = '0;
      for (int p = 0; p < NUM_PAGES; p++)
         for (int r = 0; r < REGS_PER_PAGE; r++)
            if (wr_page == PAGE_W'(p) && wr_addr == ADDR_W'(r)) begin
               w_hit = 1'b1;
               w_idx = IDX_W'(p*REGS_PER_PAGE + r);
            end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TOTAL; i++) regs[i] <= '0;
      end else if (wr_en && w_hit) begin
         regs[w_idx] <= wr_data;
      end
   end

   assign rd_data   = fetch(rd_page, rd_addr);
   assign par_rdata = fetch(par_page, par_addr);
endmodule

// File: rtl/spi_paged_regfile.sv
module spi_paged_regfile
   import spi_regfile_pkg::*;
#(
   parameter int NUM_PAGES     = 2,
   parameter int REGS_PER_PAGE = 8,
   parameter int SYNC_STAGES   = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        spi_sclk,
   input  logic        spi_cs_n,
   input  logic        spi_mosi,
   output logic        spi_miso,
   input  logic [3:0]  par_page,
   input  logic [5:0]  par_addr,
   output logic [15:0] par_rdata
);
   generate
      if (WORD_W != CMD_W + RSV_W) begin : g_bad_layout
         $error("spi_paged_regfile: command layout does not fill a word");
      end
   endgenerate

   logic              sclk_rise, sclk_fall, cs_active, mosi_s;
   logic              word_done, wr_en, rd_mode, cmd_phase;
   logic [WORD_W-1:0] rx_word, tx_word, rd_data;
   logic [PAGE_W-1:0] cur_page;
   logic [ADDR_W-1:0] cur_addr;
   phase_e            phase;
   cmd_t              cmd_in;

   spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .cs_active(cs_active), .mosi_s(mosi_s)
   );

   spi_word_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
      .tx_word(tx_word), .miso(spi_miso),
      .word_done(word_done), .rx_word(rx_word)
   );

   assign cmd_in = cmd_t'(rx_word[WORD_W-1:RSV_W]);

   spi_cmd_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
      .word_done(word_done), .cmd_in(cmd_in),
      .phase(phase), .rd_mode(rd_mode),
      .cur_page(cur_page), .cur_addr(cur_addr), .wr_en(wr_en)
   );

   spi_reg_bank #(.NUM_PAGES(NUM_PAGES), .REGS_PER_PAGE(REGS_PER_PAGE)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_page(cur_page), .wr_addr(cur_addr), .wr_data(rx_word),
      .rd_page(cur_page), .rd_addr(cur_addr), .rd_data(rd_data),
      .par_page(par_page), .par_addr(par_addr), .par_rdata(par_rdata)
   );

   assign cmd_phase = (phase == PH_CMD);
   assign tx_word   = (!cmd_phase && rd_mode) ? rd_data : '0;
endmodule

// File: rtl/spi_regfile_checker.sv
module spi_regfile_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_active,
   input logic       cmd_phase,
   input logic       word_done,
   input logic       wr_en,
   input logic       rd_mode,
   input logic [5:0] cur_addr,
   input logic       spi_miso
);
   assert_cmd_miso_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_phase |-> !spi_miso);

   assert_deselect_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_active |=> (cmd_phase && !spi_miso));

   assert_read_never_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode && !cmd_phase) |-> !wr_en);

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && !cmd_phase && cs_active) |=> (cur_addr == $past(cur_addr) + 6'd1));

   assert_cmd_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && cmd_phase && cs_active) |=> !cmd_phase);
endmodule

bind spi_paged_regfile spi_regfile_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .cmd_phase(cmd_phase),
   .word_done(word_done), .wr_en(wr_en), .rd_mode(rd_mode),
   .cur_addr(cur_addr), .spi_miso(spi_miso)
);

// File: tb/spi_paged_regfile_tb_top.sv
`timescale 1ns/1ps
module spi_paged_regfile_tb_top;
   localparam int NP = 2;
   localparam int RP = 8;
   localparam int HP = 6;
   localparam int WD = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic miso;
   logic [3:0]  par_page = '0;
   logic [5:0]  par_addr = '0;
   logic [15:0] par_rdata;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;
   logic [15:0] mdl [16][64];

   always #2 clk = ~clk;

   spi_paged_regfile #(.NUM_PAGES(NP), .REGS_PER_PAGE(RP), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_miso(miso),
      .par_page(par_page), .par_addr(par_addr), .par_rdata(par_rdata)
   );

   function automatic bit impl(int p, int a);
      return (p < NP) && (a < RP);
   endfunction

   function automatic logic [15:0] cmd(bit rd, int p, int a);
      return {rd, 4'(p), 6'(a), 5'b0};
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic spi_wait(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
      rx = '0;
      for (int i = 0; i < nbits; i++) begin
         sclk = 1'b1;
         mosi = tx[15-i];
         spi_wait(HP);
         rx = {rx[14:0], miso};
         sclk = 1'b0;
         spi_wait(HP);
      end
   endtask

   task automatic frame(input logic [15:0] tx[$], output logic [15:0] rx[$]);
      logic [15:0] w;
      rx = {};
      cs_n = 1'b0;
      spi_wait(HP);
      foreach (tx[i]) begin
         xfer(tx[i], 16, w);
         rx.push_back(w);
      end
      spi_wait(HP);
      cs_n = 1'b1;
      mosi = 1'b0;
      spi_wait(3*HP);
   endtask

   task automatic wr_frame(int p, int a, logic [15:0] data[$], logic [15:0] rsv);
      logic [15:0] tx[$];
      logic [15:0] rx[$];
      tx = {cmd(0, p, a) | rsv};
      foreach (data[k]) begin
         tx.push_back(data[k]);
         if (impl(p, (a + k) % 64)) mdl[p][(a + k) % 64] = data[k];
      end
      frame(tx, rx);
      foreach (rx[k]) check("R3 write-frame miso zero", rx[k], 16'h0);
   endtask

   task automatic rd_check(string tag, int p, int a, int n, logic [15:0] fill, logic [15:0] rsv);
      logic [15:0] tx[$];
      logic [15:0] rx[$];
      tx = {cmd(1, p, a) | rsv};
      for (int k = 0; k < n; k++) tx.push_back(fill);
      frame(tx, rx);
      check({tag, " R3 cmd word miso"}, rx[0], 16'h0);
      for (int k = 0; k < n; k++)
         check(tag, rx[k+1], mdl[p][(a + k) % 64]);
   endtask

   task automatic par_scan(string tag);
      for (int p = 0; p < 3; p++)
         for (int a = 0; a < RP + 2; a++) begin
            par_page = 4'(p);
            par_addr = 6'(a);
            #1;
            check(tag, par_rdata, mdl[p][a]);
         end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      spi_wait(3);
      rst_n = 1'b1;
      for (int p = 0; p < 16; p++)
         for (int a = 0; a < 64; a++) mdl[p][a] = '0;
      spi_wait(3);
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [15:0] tx[$];
      logic [15:0] rx[$];
      logic [15:0] w;
      spi_wait(1);
      do_reset();

      // R8: reset state
      par_scan("R8/R9 reset contents");
      check("R3 miso idle after reset", {15'b0, miso}, 16'h0);

      // R1, R4, R5: stream write then read, bit-order patterns
      wr_frame(0, 2, '{16'h8001, 16'h1234, 16'hA5C3}, 16'h0);
      rd_check("R1/R5 stream read", 0, 2, 4, 16'h0000, 16'h0);

      // R2: reserved bits set in command
      wr_frame(1, 1, '{16'hBEEF}, 16'h001F);
      rd_check("R2 reserved bits ignored", 1, 0, 3, 16'h0000, 16'h0015);

      // R5: read with all-ones on MOSI must not write
      rd_check("R5 read fill ones", 0, 2, 3, 16'hFFFF, 16'h0);
      rd_check("R5 contents after read", 0, 0, 8, 16'h0000, 16'h0);

      // R4, R7: wrap from 63 to 0 within page 1
      wr_frame(1, 63, '{16'h1111, 16'h2222, 16'h3333}, 16'h0);
      rd_check("R4 wrap read", 1, 62, 5, 16'h0, 16'h0);

      // R7: unimplemented page and address
      wr_frame(5, 0, '{16'hDEAD, 16'hCAFE}, 16'h0);
      rd_check("R7 unimplemented page", 5, 0, 2, 16'h0, 16'h0);
      wr_frame(0, 9, '{16'h7777}, 16'h0);
      rd_check("R7 unimplemented addr", 0, 8, 3, 16'h0, 16'h0);

      // R6: partial word dropped
      cs_n = 1'b0;
      spi_wait(HP);
      xfer(cmd(0, 0, 4), 16, w);
      xfer(16'hAAAA, 16, w);
      xfer(16'h5555, 9, w);
      cs_n = 1'b1;
      mosi = 1'b0;
      spi_wait(3*HP);
      mdl[0][4] = 16'hAAAA;
      rd_check("R6 partial word dropped", 0, 4, 2, 16'h0, 16'h0);

      // R10: data word shaped like a read command stays data
      wr_frame(0, 6, '{cmd(1, 1, 1), 16'h4321}, 16'h0);
      rd_check("R10 command-like data", 0, 6, 2, 16'h0, 16'h0);

      // R3: first word after a new fall is a command again
      tx = {cmd(1, 0, 3), 16'h0};
      frame(tx, rx);
      check("R3 cmd after new select", rx[0], 16'h0);
      check("R3 data after new select", rx[1], mdl[0][3]);

      // R9: parallel port scan
      par_scan("R9 parallel read");

      // R8: reset mid-run clears everything
      do_reset();
      par_scan("R8 reset clears");
      rd_check("R8 serial after reset", 0, 0, 4, 16'h0, 16'h0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule